// File: doc/BRIEF.md
# Power-Budgeted Self-Test Session Sequencer

This block steps through a fixed list of self-test sessions. In each session several tests run at the same time, each on its own pattern source and response compactor. Those engines are outside the block. The sequencer gives them a per-test enable level and a one-cycle finish strobe. Every test has a length in clocks and a power weight. The schedule is set at elaboration time by three packed parameters: per-test lengths, per-test weights and per-session membership masks.

A one-cycle start request launches the schedule. All members of a session start together. Each member stays enabled only for its own length, and the session closes when its longest member finishes. The next session follows on the next clock. A power monitor adds up the weights of the tests enabled in the current cycle. If the total is above the budget, the sequencer aborts to idle and raises a sticky error. A cycle counter reports how many clocks were spent in sessions.

With the default table, the sessions are {T3,T4}, {T2,T5} and {T1,T6}. They take 10, 10 and 100 clocks, which is 120 clocks in total, and no session goes above the budget of 4.

Top module: `bist_session_seq`

## Requirements
- R1: While reset is held and after it is released, all test enables and finish strobes are 0, the completion flag is 0, the error flag is 0 and the cycle counter is 0.
- R2: A start request sampled high while the sequencer is not running begins session 0 at the next clock edge. A start request sampled high during a run has no effect on enables, strobes or the cycle counter.
- R3: Sessions run in table order, session 0 first. Each session lasts exactly as many clocks as its longest member. The next session's first cycle follows the previous session's last cycle with no gap.
- R4: Within a session, test i's enable is high in session cycles 0 to len_i-1 and low for the rest of that session.
- R5: Test i's finish strobe is high for exactly one cycle, session cycle len_i-1, and is low otherwise.
- R6: The cycle after the last session's final cycle, the completion flag rises and all enables are low. The flag stays high until the next start request is accepted.
- R7: The cycle counter is cleared when a run starts and increases by 1 for every clock spent in a session. With the default table it reads 120 once the run completes.
- R8: If the summed weight of the tests enabled in a cycle exceeds POWER_LIMIT, then in the next cycle all enables are low, the run has ended without setting the completion flag, and the error flag is high. The error flag stays high until reset.
- R9: Encoding: bit i of a session's NUM_TESTS-bit mask, and of test_en_o and test_done_o, is test T(i+1). Session s occupies mask bits [s*NUM_TESTS +: NUM_TESTS], and session 0 is the lowest field. Test i's length and weight occupy fields [i*LEN_W +: LEN_W] and [i*PWR_W +: PWR_W].
- R10: A test that is not a member of the current session is never enabled and never strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request for the schedule |
| test_en_o | output | NUM_TESTS | Per-test enable for its pattern source and compactor |
| test_done_o | output | NUM_TESTS | Per-test one-cycle finish strobe |
| seq_done_o | output | 1 | Schedule completed |
| pwr_err_o | output | 1 | Sticky power budget violation |
| cyc_cnt_o | output | CYC_W | Clocks spent in sessions during the current or last run |

## Verification
The bound checker tests these properties on every cycle:
- No enable or strobe is asserted outside a run or outside the current session's membership.
- An over-budget cycle is followed by an abort with the error flag set, and the error flag never falls.
- The cycle counter steps by one on every running clock.
- A run continues until its natural end or an abort.

Some behaviour only the bench's scenarios can show. These are the exact enable windows and strobe positions of each test, the session boundaries and ordering, the final count of 120, a start request ignored mid-run, a repeated run, and an over-budget schedule aborting at its first cycle of session 1.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/bist_sess_table.sv
module bist_sess_table #(
   parameter int NUM_TESTS = 6,
   parameter int MAX_SESS  = 8,
   parameter int LEN_W     = 8,
   parameter logic [NUM_TESTS*LEN_W-1:0]    TEST_LEN  = '0,
   parameter logic [MAX_SESS*NUM_TESTS-1:0] SESS_MASK = '0,
   localparam int SIDX_W = $clog2(MAX_SESS)
) (
   input  logic [SIDX_W-1:0]    sess_idx_i,
   output logic [NUM_TESTS-1:0] mask_o,
   output logic [LEN_W-1:0]     slen_o
);
   logic [LEN_W-1:0] slen_tab [MAX_SESS];

   for (genvar s = 0; s < MAX_SESS; s++) begin : g_sess
      logic [LEN_W-1:0] longest;
      always_comb begin
         longest = '0;
         for (int t = 0; t < NUM_TESTS; t++) begin
            if (SESS_MASK[s*NUM_TESTS + t] &&
                TEST_LEN[t*LEN_W +: LEN_W] > longest)
               longest = TEST_LEN[t*LEN_W +: LEN_W];
         end
      end
      assign slen_tab[s] = longest;
   end

   assign mask_o = SESS_MASK[sess_idx_i*NUM_TESTS +: NUM_TESTS];
   assign slen_o = slen_tab[sess_idx_i];
endmodule

// File: rtl/bist_test_gate.sv
module bist_test_gate #(
   parameter int LEN_W = 8,
   parameter int PWR_W = 4,
   parameter int LEN   = 1,
   parameter int PWR   = 0
) (
   input  logic             run_i,
   input  logic             member_i,
   input  logic [LEN_W-1:0] cnt_i,
   output logic             en_o,
   output logic             done_o,
   output logic [PWR_W-1:0] pwr_o
);
   localparam logic [LEN_W-1:0] LEN_V  = LEN_W'(LEN);
   localparam logic [LEN_W-1:0] LAST_V = LEN_W'(LEN - 1);

   logic active;
   assign active = run_i & member_i;
   assign en_o   = active && (cnt_i < LEN_V);
   assign done_o = active && (cnt_i == LAST_V);

   if (PWR == 0) begin : g_no_weight
      assign pwr_o = '0;
   end else begin : g_weight
      assign pwr_o = en_o ? PWR_W'(PWR) : '0;
   end
endmodule

// File: rtl/bist_power_sum.sv
module bist_power_sum #(
   parameter int NUM_TESTS   = 6,
   parameter int PWR_W       = 4,
   parameter int POWER_LIMIT = 4,
   localparam int SUM_W = PWR_W + $clog2(NUM_TESTS + 1)
) (
   input  logic [NUM_TESTS*PWR_W-1:0] pwr_i,
   output logic [SUM_W-1:0]           sum_o,
   output logic                       over_o
);
   always_comb begin
      sum_o = '0;
      for (int t = 0; t < NUM_TESTS; t++)
         sum_o = sum_o + SUM_W'(pwr_i[t*PWR_W +: PWR_W]);
   end
   assign over_o = sum_o > SUM_W'(POWER_LIMIT);
endmodule

// File: rtl/bist_session_seq.sv
module bist_session_seq
   import bist_seq_pkg::*;
#(
   parameter int NUM_TESTS   = 6,
   parameter int MAX_SESS    = 8,
   parameter int NUM_SESS    = 3,
   parameter int LEN_W       = 8,
   parameter int PWR_W       = 4,
   parameter int CYC_W       = 16,
   parameter int POWER_LIMIT = 4,
   parameter logic [NUM_TESTS*LEN_W-1:0] TEST_LEN =
      {8'd100, 8'd10, 8'd5, 8'd10, 8'd10, 8'd100},
   parameter logic [NUM_TESTS*PWR_W-1:0] TEST_PWR =
      {4'd1, 4'd2, 4'd1, 4'd1, 4'd1, 4'd2},
   parameter logic [MAX_SESS*NUM_TESTS-1:0] SESS_MASK =
      {30'd0, 6'b100001, 6'b010010, 6'b001100}
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 start_i,
   output logic [NUM_TESTS-1:0] test_en_o,
   output logic [NUM_TESTS-1:0] test_done_o,
   output logic                 seq_done_o,
   output logic                 pwr_err_o,
   output logic [CYC_W-1:0]     cyc_cnt_o
);
   localparam int SIDX_W = $clog2(MAX_SESS);
   localparam int SUM_W  = PWR_W + $clog2(NUM_TESTS + 1);
   localparam logic [SIDX_W-1:0] LAST_SESS = SIDX_W'(NUM_SESS - 1);

   // elaboration-time parameter checks
   if (NUM_SESS < 1 || NUM_SESS > MAX_SESS) begin : g_bad_nsess
      $error("NUM_SESS must lie in 1..MAX_SESS");
   end
   if (MAX_SESS < 2 || (1 << SIDX_W) != MAX_SESS) begin : g_bad_msess
      $error("MAX_SESS must be a power of two of at least 2");
   end
   if (POWER_LIMIT < 0 || POWER_LIMIT >= (1 << SUM_W)) begin : g_bad_limit
      $error("POWER_LIMIT out of range for the sum width");
   end
   for (genvar t = 0; t < NUM_TESTS; t++) begin : g_chk_len
      if (TEST_LEN[t*LEN_W +: LEN_W] == '0) begin : g_zero
         $error("test length must be nonzero");
      end
   end
   for (genvar s = 0; s < NUM_SESS; s++) begin : g_chk_mask
      if (SESS_MASK[s*NUM_TESTS +: NUM_TESTS] == '0) begin : g_empty
         $error("scheduled session has no member");
      end
   end

   seq_state_e          state_q;
   logic [SIDX_W-1:0]   sess_q;
   logic [LEN_W-1:0]    cnt_q;
   logic                err_q;
   logic [CYC_W-1:0]    cyc_q;
   logic                run;
   logic [NUM_TESTS-1:0] mask_cur;
   logic [LEN_W-1:0]    slen_cur;
   logic                sess_end;
   logic                seq_end;
   logic [NUM_TESTS*PWR_W-1:0] pwr_vec;
   logic [SUM_W-1:0]    pwr_sum;
   logic                pwr_over;

   assign run      = (state_q == ST_RUN);
   assign sess_end = run && (cnt_q == slen_cur - 1'b1);
   assign seq_end  = sess_end && (sess_q == LAST_SESS);

   bist_sess_table #(
      .NUM_TESTS (NUM_TESTS),
      .MAX_SESS  (MAX_SESS),
      .LEN_W     (LEN_W),
      .TEST_LEN  (TEST_LEN),
      .SESS_MASK (SESS_MASK)
   ) u_table (
      .sess_idx_i (sess_q),
      .mask_o     (mask_cur),
      .slen_o     (slen_cur)
   );

   for (genvar t = 0; t < NUM_TESTS; t++) begin : g_test
      bist_test_gate #(
         .LEN_W (LEN_W),
         .PWR_W (PWR_W),
         .LEN   (int'(TEST_LEN[t*LEN_W +: LEN_W])),
         .PWR   (int'(TEST_PWR[t*PWR_W +: PWR_W]))
      ) u_gate (
         .run_i    (run),
         .member_i (mask_cur[t]),
         .cnt_i    (cnt_q),
         .en_o     (test_en_o[t]),
         .done_o   (test_done_o[t]),
         .pwr_o    (pwr_vec[t*PWR_W +: PWR_W])
      );
   end

   bist_power_sum #(
      .NUM_TESTS   (NUM_TESTS),
      .PWR_W       (PWR_W),
      .POWER_LIMIT (POWER_LIMIT)
   ) u_power (
      .pwr_i  (pwr_vec),
      .sum_o  (pwr_sum),
      .over_o (pwr_over)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         sess_q  <= '0;
         cnt_q   <= '0;
         err_q   <= 1'b0;
         cyc_q   <= '0;
      end else begin
         case (state_q)
            ST_RUN: begin
               cyc_q <= cyc_q + 1'b1;
               if (pwr_over) begin
                  state_q <= ST_IDLE;
                  err_q   <= 1'b1;
               end else if (sess_end) begin
                  cnt_q <= '0;
                  if (seq_end) state_q <= ST_FIN;
                  else         sess_q  <= sess_q + 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (start_i) begin
                  state_q <= ST_RUN;
                  sess_q  <= '0;
                  cnt_q   <= '0;
                  cyc_q   <= '0;
               end
            end
         endcase
      end
   end

   assign seq_done_o = (state_q == ST_FIN);
   assign pwr_err_o  = err_q;
   assign cyc_cnt_o  = cyc_q;
endmodule

// File: rtl/bist_session_seq_chk.sv
module bist_session_seq_chk #(
   parameter int NUM_TESTS = 6,
   parameter int CYC_W     = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 run,
   input logic                 over,
   input logic                 fin,
   input logic [NUM_TESTS-1:0] en,
   input logic [NUM_TESTS-1:0] tdone,
   input logic [NUM_TESTS-1:0] mask,
   input logic                 done,
   input logic                 err,
   input logic [CYC_W-1:0]     cyc
);
   p_member_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((en | tdone) & ~mask) == '0);

   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (en == '0 && tdone == '0));

   p_done_not_running_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !run);

   p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && over) |=> (!run && err && !done));

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   p_cyc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (cyc == CYC_W'($past(cyc) + 1'b1)));

   p_keep_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !over && !fin) |=> run);
endmodule

bind bist_session_seq bist_session_seq_chk #(
   .NUM_TESTS (NUM_TESTS),
   .CYC_W     (CYC_W)
) u_chk (
   .clk   (clk_i),
   .rst_n (rst_ni),
   .run   (run),
   .over  (pwr_over),
   .fin   (seq_end),
   .en    (test_en_o),
   .tdone (test_done_o),
   .mask  (mask_cur),
   .done  (seq_done_o),
   .err   (pwr_err_o),
   .cyc   (cyc_cnt_o)
);

// File: tb/bist_session_seq_tb.sv
module bist_session_seq_tb;
   localparam int NT = 6;
   localparam int NS = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_a = 1'b0;
   logic start_b = 1'b0;
   logic [NT-1:0] en_a, dn_a, en_b, dn_b;
   logic done_a, err_a, done_b, err_b;
   logic [15:0] cyc_a, cyc_b;

   int n_checks = 0;
   int n_fail = 0;

   // bench's own view of the schedule (R9 encoding: bit i is test T(i+1))
   int tlen [NT] = '{100, 10, 10, 5, 10, 100};
   logic [NT-1:0] smask [NS] = '{6'b001100, 6'b010010, 6'b100001};

   always #2 clk = ~clk;

   bist_session_seq u_dut (
      .clk_i (clk), .rst_ni (rst_n), .start_i (start_a),
      .test_en_o (en_a), .test_done_o (dn_a),
      .seq_done_o (done_a), .pwr_err_o (err_a), .cyc_cnt_o (cyc_a)
   );

   bist_session_seq #(.POWER_LIMIT(2)) u_dut_ovr (
      .clk_i (clk), .rst_ni (rst_n), .start_i (start_b),
      .test_en_o (en_b), .test_done_o (dn_b),
      .seq_done_o (done_b), .pwr_err_o (err_b), .cyc_cnt_o (cyc_b)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int slen(int s);
      int m = 0;
      for (int i = 0; i < NT; i++)
         if (smask[s][i] && tlen[i] > m) m = tlen[i];
      return m;
   endfunction

   function automatic int total_len();
      int t = 0;
      for (int s = 0; s < NS; s++) t += slen(s);
      return t;
   endfunction

   task automatic model(input int c, output logic [NT-1:0] e, output logic [NT-1:0] d);
      int base = 0;
      e = '0;
      d = '0;
      for (int s = 0; s < NS; s++) begin
         int l = slen(s);
         if (c >= base && c < base + l) begin
            for (int i = 0; i < NT; i++) begin
               if (smask[s][i]) begin
                  e[i] = (c - base) < tlen[i];
                  d[i] = (c - base) == tlen[i] - 1;
               end
            end
         end
         base += l;
      end
   endtask

   // full run on the in-budget instance; poke_at >= 0 pulses start mid-run
   task automatic run_full(input int poke_at);
      logic [NT-1:0] ee, ed;
      int tot = total_len();
      start_a = 1'b1;
      for (int c = 0; c < tot; c++) begin
         @(negedge clk);
         start_a = (c == poke_at);
         model(c, ee, ed);
         chk(en_a == ee, "R4/R3", $sformatf("enables cycle %0d", c), en_a, ee);
         chk(dn_a == ed, "R5", $sformatf("strobes cycle %0d", c), dn_a, ed);
         if (c % 10 == 0 || c == poke_at + 1)
            chk(cyc_a == c, "R7", "running count", cyc_a, c);
         if (c == 0) chk(done_a == 1'b0, "R6", "done cleared at start", done_a, 0);
         if (c == poke_at + 1) chk(en_a == ee, "R2", "start ignored mid-run", en_a, ee);
      end
      @(negedge clk);
      start_a = 1'b0;
      chk(done_a == 1'b1, "R6", "done after last session", done_a, 1);
      chk(en_a == '0, "R6", "enables low at end", en_a, 0);
      chk(cyc_a == 16'(tot), "R7", "final count", cyc_a, tot);
      chk(tot == 120, "R3", "schedule length", tot, 120);
      repeat (5) @(negedge clk);
      chk(done_a == 1'b1, "R6", "done holds", done_a, 1);
      chk(cyc_a == 16'(tot), "R7", "count holds", cyc_a, tot);
   endtask

   initial begin : main
      logic [NT-1:0] ee, ed;
      repeat (3) @(negedge clk);
      chk(en_a == '0 && dn_a == '0, "R1", "outputs in reset", en_a | dn_a, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done_a == 1'b0, "R1", "done after reset", done_a, 0);
      chk(err_a == 1'b0 && err_b == 1'b0, "R1", "error after reset", err_a | err_b, 0);
      chk(cyc_a == '0, "R1", "count after reset", cyc_a, 0);
      repeat (3) @(negedge clk);
      chk(en_a == '0, "R2", "idle without start", en_a, 0);

      run_full(-1);
      run_full(50);
      chk(err_a == 1'b0, "R8", "no error within budget", err_a, 0);

      // over-budget schedule: session 1 weighs 3 against a limit of 2
      start_b = 1'b1;
      for (int c = 0; c <= 11; c++) begin
         @(negedge clk);
         start_b = 1'b0;
         model(c, ee, ed);
         if (c <= 10) begin
            chk(en_b == ee, "R10", $sformatf("ovr enables cycle %0d", c), en_b, ee);
            chk(err_b == 1'b0, "R8", "no error before overload", err_b, 0);
         end else begin
            chk(err_b == 1'b1, "R8", "error after overload", err_b, 1);
            chk(en_b == '0, "R8", "enables dropped", en_b, 0);
            chk(done_b == 1'b0, "R8", "no completion on abort", done_b, 0);
            chk(cyc_b == 16'd11, "R8", "count at abort", cyc_b, 11);
         end
      end
      repeat (4) @(negedge clk);
      chk(err_b == 1'b1, "R8", "error sticky", err_b, 1);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin : watchdog
      #(4 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule